// File: doc/BRIEF.md
# DDS Phase Accumulator with Power-of-Two Post-Divider

The block synthesizes a square wave in two stages. The first stage runs on a fast reference clock. On every edge it adds a tuning word N to a wrapping phase register that is `ACC_W` bits wide. The top bit of that register is the synthesized wave, so its average frequency is N / 2^ACC_W times the reference frequency. With a 200 MHz reference the wave has 5 ns edge resolution. When the ideal period is not a whole number of reference clocks, the wave alternates between the two nearest whole-clock periods so that the average frequency is correct.

The second stage runs on its own clock. In a full system that clock is a cleaned and multiplied copy of the synthesized wave. The second stage is a free-running binary counter. A select word D picks one counter bit as the output, which gives a coarse division by 2^(D+1).

A host writes N and D through load strobes, each synchronous to its own clock. Changing N leaves the accumulated phase untouched. Tuning words above a ceiling are clamped to it. A fixed-frequency variant, chosen by parameter, replaces the loaded N with a constant and the select multiplexer with a hard-wired counter bit.

Top module: `dds_pow2_synth`

## Requirements
- R1: On every rising edge of `ref_clk_i` the phase register advances by the stored tuning word, modulo 2^ACC_W. `synth_o` is the top bit of the phase register.
- R2: While `tune_ld_i` is high at a rising edge of `ref_clk_i`, that edge stores `tune_word_i`. The stored word is first added at the following edge. A load never alters the accumulated phase.
- R3: A `tune_word_i` above `TUNE_MAX` (default 0x0FFFFFEA) is stored as `TUNE_MAX`. Any word at or below the ceiling is stored unchanged.
- R4: After reset, with N = 0x10000000 `synth_o` settles into runs of exactly 8 cycles low and 8 cycles high. With N = 0x08000000 the runs are exactly 16 low and 16 high.
- R5: With N = 0x0FE353F7, every rising-to-rising period of `synth_o` is 16 or 17 reference cycles. Both lengths occur, and 17-cycle periods make up between 1/12 and 1/6 of all periods.
- R6: The divider counter increments on every rising edge of `div_clk_i`. `div_o` equals counter bit D, so `div_o` is a square wave with half-period 2^D cycles (division by 2^(D+1)).
- R7: While `scale_ld_i` is high at a rising edge of `div_clk_i`, that edge stores `scale_i`, and `div_o` follows the new bit from that edge on. Without a load, changes on `scale_i` have no effect on `div_o`.
- R8: A select value above CNT_W-1 picks counter bit CNT_W-1.
- R9: While `rst_ni` is low, the phase register, the stored tuning word, the counter and the stored select are zero, so `synth_o` and `div_o` are 0.
- R10: With `FIXED` = 1 the accumulator adds `FIXED_TUNE` from the first edge after reset and `div_o` is counter bit `FIXED_TAP`. Both load strobes and their data are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Fast reference clock for the phase accumulator |
| div_clk_i | input | 1 | Clock for the power-of-two divider |
| rst_ni | input | 1 | Asynchronous active-low reset for both stages |
| tune_ld_i | input | 1 | Tuning word load strobe, synchronous to `ref_clk_i` |
| tune_word_i | input | ACC_W | Tuning word N |
| scale_ld_i | input | 1 | Select load strobe, synchronous to `div_clk_i` |
| scale_i | input | SEL_W | Divider select D |
| synth_o | output | 1 | Top bit of the phase register (synthesized wave) |
| div_o | output | 1 | Selected divider counter bit |

## Verification
The wrap property assumes that every stored tuning word stays below half the phase range. That is why a falling top bit must coincide with a wrap, and the stimulus includes over-ceiling words so that the clamp has to keep the property true. The divider properties assume a counter that free-runs from reset and loads that arrive only as single-cycle strobes in their own clock domain. The bench changes strobes and data on the falling edge of the matching clock and releases reset away from the edges of the domain under test. The bench sweeps every select value on a counter eight bits deep and compares both stages, cycle by cycle, against an arithmetic model. Both load paths are also driven on the fixed instance, to show that its outputs are unaffected.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DEF_ACC_W    = 32;
  localparam int unsigned DEF_SEL_W    = 5;
  localparam int unsigned DEF_CNT_W    = 24;
  localparam logic [31:0] DEF_TUNE_MAX = 32'h0FFF_FFEA;

  // width of an index that can address depth entries
  function automatic int unsigned idx_w(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned          ACC_W      = dds_pkg::DEF_ACC_W,
  parameter logic [ACC_W-1:0]     TUNE_MAX   = dds_pkg::DEF_TUNE_MAX,
  parameter bit                   FIXED      = 1'b0,
  parameter logic [ACC_W-1:0]     FIXED_TUNE = dds_pkg::DEF_TUNE_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tune_ld_i,
  input  logic [ACC_W-1:0] tune_word_i,
  output logic             synth_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] n_q;

  generate
    if (FIXED) begin : g_fixed
      logic unused_ld;
      assign unused_ld = ^{tune_ld_i, tune_word_i};
      assign n_q = FIXED_TUNE;
    end else begin : g_loaded
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          n_q <= '0;
        else if (tune_ld_i)
          n_q <= (tune_word_i > TUNE_MAX) ? TUNE_MAX : tune_word_i;
      end

      p_tune_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tune_ld_i |=> $stable(n_q));

      p_tune_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        n_q <= TUNE_MAX);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + n_q;
  end

  assign synth_o = acc_q[ACC_W-1];

  // step stays below half range, so a falling top bit means a wrap
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acc_q[ACC_W-1]) |-> (acc_q < $past(n_q)));
endmodule

// File: rtl/dds_pow2_div.sv
module dds_pow2_div #(
  parameter int unsigned SEL_W     = dds_pkg::DEF_SEL_W,
  parameter int unsigned CNT_W     = dds_pkg::DEF_CNT_W,
  parameter bit          FIXED     = 1'b0,
  parameter int unsigned FIXED_TAP = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scale_ld_i,
  input  logic [SEL_W-1:0] scale_i,
  output logic             div_o
);
  localparam int unsigned TAP_W = dds_pkg::idx_w(CNT_W);
  localparam int unsigned TOP   = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (FIXED) begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^{scale_ld_i, scale_i};
      assign div_o = cnt_q[FIXED_TAP];
    end else begin : g_mux
      logic [TAP_W-1:0]      tap_q;
      logic [TAP_W-1:0]      tap_nxt;
      logic [2**TAP_W-1:0]   tap_vec;
      logic                  past_ok_q;

      // out-of-range select saturates to the deepest bit
      always_comb begin
        if (32'(scale_i) > 32'(TOP)) tap_nxt = TAP_W'(TOP);
        else                         tap_nxt = TAP_W'(scale_i);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         tap_q <= '0;
        else if (scale_ld_i) tap_q <= tap_nxt;
      end

      always_comb begin
        tap_vec            = '0;
        tap_vec[CNT_W-1:0] = cnt_q;
      end

      assign div_o = tap_vec[tap_q];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok_q <= 1'b0;
        else         past_ok_q <= 1'b1;
      end

      p_lsb_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && tap_q == '0 && $past(tap_q) == '0) |-> (div_o != $past(div_o)));

      p_scale_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scale_ld_i |=> $stable(tap_q));

      p_tap_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(tap_q) <= 32'(TOP));
    end
  endgenerate
endmodule

// File: rtl/dds_pow2_synth.sv
module dds_pow2_synth #(
  parameter int unsigned      ACC_W      = dds_pkg::DEF_ACC_W,
  parameter logic [ACC_W-1:0] TUNE_MAX   = dds_pkg::DEF_TUNE_MAX,
  parameter int unsigned      SEL_W      = dds_pkg::DEF_SEL_W,
  parameter int unsigned      CNT_W      = dds_pkg::DEF_CNT_W,
  parameter bit               FIXED      = 1'b0,
  parameter logic [ACC_W-1:0] FIXED_TUNE = dds_pkg::DEF_TUNE_MAX,
  parameter int unsigned      FIXED_TAP  = 0
) (
  input  logic             ref_clk_i,
  input  logic             div_clk_i,
  input  logic             rst_ni,
  input  logic             tune_ld_i,
  input  logic [ACC_W-1:0] tune_word_i,
  input  logic             scale_ld_i,
  input  logic [SEL_W-1:0] scale_i,
  output logic             synth_o,
  output logic             div_o
);
  dds_phase_acc #(
    .ACC_W      (ACC_W),
    .TUNE_MAX   (TUNE_MAX),
    .FIXED      (FIXED),
    .FIXED_TUNE (FIXED_TUNE)
  ) u_acc (
    .clk_i       (ref_clk_i),
    .rst_ni      (rst_ni),
    .tune_ld_i   (tune_ld_i),
    .tune_word_i (tune_word_i),
    .synth_o     (synth_o)
  );

  dds_pow2_div #(
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W),
    .FIXED     (FIXED),
    .FIXED_TAP (FIXED_TAP)
  ) u_div (
    .clk_i      (div_clk_i),
    .rst_ni     (rst_ni),
    .scale_ld_i (scale_ld_i),
    .scale_i    (scale_i),
    .div_o      (div_o)
  );
endmodule

// File: tb/dds_pow2_synth_test.sv
module dds_pow2_synth_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIV_PERIOD = 14;
  localparam logic [31:0] TMAX       = 32'h0FFF_FFEA;
  localparam logic [31:0] FIX_N      = 32'h0800_0000;
  localparam int          FIX_TAP    = 2;
  localparam int          DEEP       = 7;

  logic        ref_clk = 1'b0;
  logic        div_clk = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        tune_ld = 1'b0;
  logic [31:0] tune_word = '0;
  logic        scale_ld = 1'b0;
  logic [4:0]  scale = '0;
  logic        synth, divo, fsynth, fdiv;

  int          n_chk  = 0;
  int          n_fail = 0;
  logic [31:0] m_acc, m_n, m_facc;
  logic [7:0]  m_cnt;
  int          m_tap;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(DIV_PERIOD/2) div_clk = ~div_clk;

  dds_pow2_synth #(.CNT_W(8)) uut (
    .ref_clk_i(ref_clk), .div_clk_i(div_clk), .rst_ni(rst_ni),
    .tune_ld_i(tune_ld), .tune_word_i(tune_word),
    .scale_ld_i(scale_ld), .scale_i(scale),
    .synth_o(synth), .div_o(divo));

  dds_pow2_synth #(.CNT_W(8), .FIXED(1'b1), .FIXED_TUNE(FIX_N), .FIXED_TAP(FIX_TAP)) uut_fix (
    .ref_clk_i(ref_clk), .div_clk_i(div_clk), .rst_ni(rst_ni),
    .tune_ld_i(tune_ld), .tune_word_i(tune_word),
    .scale_ld_i(scale_ld), .scale_i(scale),
    .synth_o(fsynth), .div_o(fdiv));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] clamp(input logic [31:0] w);
    return (w > TMAX) ? TMAX : w;
  endfunction

  task automatic do_reset(input bit on_div);
    rst_ni = 1'b0; tune_ld = 1'b0; scale_ld = 1'b0;
    repeat (3) @(posedge ref_clk);
    #1;
    chk(synth == 1'b0, "R9 synth", synth, 0);
    chk(divo == 1'b0, "R9 div", divo, 0);
    chk(fsynth == 1'b0 && fdiv == 1'b0, "R9 fixed", {fsynth, fdiv}, 0);
    if (on_div) @(negedge div_clk); else @(negedge ref_clk);
    rst_ni = 1'b1;
    m_acc = '0; m_n = '0; m_facc = '0; m_cnt = '0; m_tap = 0;
  endtask

  // starts and ends on a falling ref edge
  task automatic ref_step(input bit ld, input logic [31:0] w, input string tag);
    tune_ld = ld; tune_word = w;
    @(posedge ref_clk);
    m_acc  = m_acc + m_n;
    m_facc = m_facc + FIX_N;
    if (ld) m_n = clamp(w);
    @(negedge ref_clk);
    tune_ld = 1'b0;
    chk(synth == m_acc[31], tag, synth, m_acc[31]);
    chk(fsynth == m_facc[31], "R10 fixed synth", fsynth, m_facc[31]);
  endtask

  task automatic div_step(input bit ld, input logic [4:0] d, input string tag);
    scale_ld = ld; scale = d;
    @(posedge div_clk);
    m_cnt = m_cnt + 8'd1;
    if (ld) m_tap = (int'(d) > DEEP) ? DEEP : int'(d);
    @(negedge div_clk);
    scale_ld = 1'b0;
    chk(divo == m_cnt[m_tap], tag, divo, m_cnt[m_tap]);
    chk(fdiv == m_cnt[FIX_TAP], "R10 fixed div", fdiv, m_cnt[FIX_TAP]);
  endtask

  task automatic run_square(input logic [31:0] n, input int half);
    logic prev;
    int   len;
    bit   first;
    ref_step(1'b1, n, "R2 load");
    prev = synth; len = 1; first = 1'b1;
    for (int i = 0; i < 20 * half; i++) begin
      ref_step(1'b0, '0, "R1 accumulate");
      if (synth == prev) len++;
      else begin
        if (!first) chk(len == half, "R4 run length", len, half);
        first = 1'b0; prev = synth; len = 1;
      end
    end
  endtask

  task automatic run_mixed();
    logic prev;
    int   since, n16, n17, nper;
    bit   seen;
    ref_step(1'b1, 32'h0FE3_53F7, "R2 load");
    prev = synth; since = 0; seen = 1'b0; n16 = 0; n17 = 0; nper = 0;
    for (int i = 0; i < 5000; i++) begin
      ref_step(1'b0, '0, "R1 accumulate");
      since++;
      if (synth && !prev) begin
        if (seen) begin
          chk(since == 16 || since == 17, "R5 period", since, 16);
          if (since == 16) n16++;
          if (since == 17) n17++;
          nper++;
        end
        seen = 1'b1; since = 0;
      end
      prev = synth;
    end
    chk(n16 > 0 && n17 > 0, "R5 both lengths", n17, 1);
    chk(n17 * 12 >= nper && n17 * 6 <= nper, "R5 long share", n17, nper / 9);
  endtask

  task automatic run_div_sweep();
    logic prev;
    int   len, half, tap;
    bit   first;
    for (int d = 0; d < 32; d++) begin
      tap  = (d > DEEP) ? DEEP : d;
      half = 1 << tap;
      div_step(1'b1, 5'(d), (d > DEEP) ? "R8 load" : "R7 load");
      prev = divo; len = 1; first = 1'b1;
      for (int i = 0; i < 4 * half + 4; i++) begin
        div_step(1'b0, 5'(d), (d > DEEP) ? "R8 select" : "R6 select");
        if (divo == prev) len++;
        else begin
          if (!first) chk(len == half, (d > DEEP) ? "R8 half period" : "R6 half period", len, half);
          first = 1'b0; prev = divo; len = 1;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    run_square(32'h1000_0000, 8);
    do_reset(1'b0);
    run_square(32'h0800_0000, 16);
    do_reset(1'b0);
    run_mixed();

    // phase continuity across loads and the ceiling clamp
    do_reset(1'b0);
    ref_step(1'b1, 32'h0123_4567, "R2 load");
    for (int i = 0; i < 60; i++) ref_step(1'b0, 32'hFFFF_FFFF, "R2 ignore data");
    ref_step(1'b1, 32'hFFFF_FFFF, "R3 over ceiling");
    for (int i = 0; i < 60; i++) ref_step(1'b0, '0, "R3 clamped");
    ref_step(1'b1, TMAX + 32'd1, "R3 just above");
    for (int i = 0; i < 40; i++) ref_step(1'b0, '0, "R3 clamped");
    ref_step(1'b1, TMAX, "R3 at ceiling");
    for (int i = 0; i < 40; i++) ref_step(1'b0, '0, "R3 exact");
    ref_step(1'b1, 32'h0000_0000, "R2 zero word");
    for (int i = 0; i < 20; i++) ref_step(1'b0, '0, "R2 phase held");

    do_reset(1'b1);
    run_div_sweep();
    div_step(1'b1, 5'd3, "R7 load");
    for (int i = 0; i < 40; i++) div_step(1'b0, 5'd5, "R7 no load");
    div_step(1'b1, 5'd0, "R7 reload");
    for (int i = 0; i < 8; i++) div_step(1'b0, 5'd31, "R6 lsb");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule